// File: doc/BRIEF.md
# Two-Wire Configuration EEPROM Slave

This block is a serial two-wire bus slave that fronts a 256-byte memory, the kind of store that holds a plug-in module's configuration bytes. A fast system clock samples the bus clock and data lines. The slave pulls the data line low only through an output-enable, so the line stays open-drain. A bus master can write one byte, read the byte that follows the last one accessed, or read any chosen byte. For a chosen-byte read, the master loads a word address with a write that carries no data and then issues a repeated start for a read.

One word-address pointer serves both directions. After every completed access it points one past the byte that was touched, and it wraps at the top of the array. The memory is an ordinary register file inside the block.

Top module: `eeprom_slave`

## Requirements
- R1: After reset the data-line enable is released, the address pointer is 0 and every memory byte reads 0x00.
- R2: The device address is the seven bits {1010, dev_sel[2:0]}, sent MSB first and followed by the R/W bit (1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch it never pulls SDA low and ignores all further bytes until the next start or stop.
- R3: A byte write is start, address with write, word address, data byte, then stop. Each of the three bytes is acknowledged. The byte is stored at the stop, and the pointer then equals the word address plus one.
- R4: A read with no new word address returns the byte at the pointer, MSB first, on the eight clocks after the address acknowledge. The pointer then advances by one.
- R5: A word address followed by a repeated start and a read request writes nothing. The read returns the byte at that word address, and the pointer becomes that address plus one.
- R6: The pointer wraps from 255 to 0.
- R7: When the master does not acknowledge the ninth clock of a read, the slave releases SDA and stays silent until the next start or stop.
- R8: A start or stop is recognised in any state and clears the bit count. A received data byte that is followed by a repeated start instead of a stop is discarded.
- R9: The SDA enable changes only while the synchronised SCL is low, apart from the release at a start or stop. An acknowledge is held low for the whole high period of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| dev_sel | input | 3 | Low three bits of the device address |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
An SCL edge reaches the control logic after two synchroniser flops and one edge register. The SDA enable therefore moves on the third clock edge after the master lowers SCL. The bench holds each SCL low phase for 20 cycles and changes its own SDA drive 4 cycles into that phase. It then compares the enable against the reference model on every cycle of the following 20-cycle high phase, when the enable must already be settled. A stored byte appears only after the stop, so the bench checks writes through later reads, and its reference pointer moves at the same transaction boundaries as the requirements.

// File: rtl/eeprom_pkg.sv
// Shared types for the two-wire EEPROM slave.
// Assumes: the control FSM is the only user of the state encoding.
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADR,
        ST_WADR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RACK,
        ST_WAIT
    } ee_state_t;

endpackage

// File: rtl/eeprom_sync.sv
// Multi-stage synchroniser for asynchronous bus pins.
// Assumes: the idle value of every line is 1 (pulled up), so reset loads ones.
module eeprom_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= d_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/eeprom_bus_events.sv
// Edge and condition detector on the synchronised SCL/SDA.
// Assumes: inputs are already synchronised; outputs are one-cycle pulses.
module eeprom_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q, sda_q;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_lvl  = scl_s;
    assign sda_lvl  = sda_s;
    assign scl_rise = !scl_q && scl_s;
    assign scl_fall = scl_q && !scl_s;
    assign start_ev = scl_q && scl_s && sda_q && !sda_s;
    assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/eeprom_regfile.sv
// Byte-wide register-file memory with one write port and one combinational read port.
// Assumes: a write and a read of the same address in one cycle return the old byte.
module eeprom_regfile #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/eeprom_ctrl.sv
// Protocol engine: address match, word-address load, byte write and byte read.
// Assumes: DW is 8 (one bus byte), AW <= DW, and SCL phases last several clk cycles.
module eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int         AW     = 8,
    parameter int         DW     = 8,
    parameter logic [3:0] DEV_HI = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_lvl,
    input  logic          sda_lvl,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic [2:0]    dev_sel,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] mem_raddr,
    output logic          sda_oe
);

    localparam int          CW       = $clog2(DW + 1);
    localparam logic [CW-1:0] BYTE_END = CW'(DW);

    ee_state_t     state;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic [DW-1:0] tx;
    logic [AW-1:0] ptr;
    logic [AW-1:0] pend_addr;
    logic [DW-1:0] pend_data;
    logic          pend_valid;
    logic          rw_bit;
    logic          oe_q;

    // A pending byte is stored only when a stop arrives.
    assign mem_we    = stop_ev && pend_valid;
    assign mem_waddr = pend_addr;
    assign mem_wdata = pend_data;
    assign mem_raddr = ptr;
    assign sda_oe    = oe_q;

    // Main protocol state machine; start and stop take priority in any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            tx         <= '0;
            ptr        <= '0;
            pend_addr  <= '0;
            pend_data  <= '0;
            pend_valid <= 1'b0;
            rw_bit     <= 1'b0;
            oe_q       <= 1'b0;
        end else if (start_ev) begin
            state      <= ST_DEV;
            bit_cnt    <= '0;
            oe_q       <= 1'b0;
            pend_valid <= 1'b0;
        end else if (stop_ev) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            if (pend_valid) begin
                ptr        <= pend_addr + 1'b1;
                pend_valid <= 1'b0;
            end
        end else begin
            case (state)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[DW-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall && bit_cnt == BYTE_END) begin
                        oe_q <= 1'b1;
                        if (state == ST_DEV) begin
                            if (shreg[DW-1:1] == {DEV_HI, dev_sel}) begin
                                rw_bit <= shreg[0];
                                state  <= ST_DEV_ACK;
                            end else begin
                                oe_q  <= 1'b0;
                                state <= ST_WAIT;
                            end
                        end else if (state == ST_WADR) begin
                            ptr   <= shreg[AW-1:0];
                            state <= ST_WADR_ACK;
                        end else begin
                            pend_addr  <= ptr;
                            pend_data  <= shreg;
                            pend_valid <= 1'b1;
                            state      <= ST_WDAT_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw_bit) begin
                            tx    <= mem_rdata;
                            oe_q  <= !mem_rdata[DW-1];
                            ptr   <= ptr + 1'b1;
                            state <= ST_RDAT;
                        end else begin
                            oe_q  <= 1'b0;
                            state <= ST_WADR;
                        end
                    end
                end
                ST_WADR_ACK: begin
                    if (scl_fall) begin
                        oe_q    <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WDAT;
                    end
                end
                ST_WDAT_ACK: begin
                    if (scl_fall) begin
                        oe_q  <= 1'b0;
                        state <= ST_WAIT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == BYTE_END) begin
                            oe_q  <= 1'b0;
                            state <= ST_RACK;
                        end else begin
                            oe_q <= !tx[DW-2];
                            tx   <= {tx[DW-2:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) state <= ST_WAIT;
                end
                default: ;
            endcase
        end
    end

    // R9: the enable moves only while SCL is low, apart from start/stop release.
    a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(oe_q) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_lvl));

    // R2, R7: idle, ignoring or post-read states never pull the line.
    a_r2_silent_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT || state == ST_IDLE) |-> !oe_q);

    // R3: a commit leaves the pointer one past the stored address.
    a_r3_commit_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ptr == $past(mem_waddr) + 1'b1);

    // R8: a start always reopens address reception with a clear bit count.
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_DEV && bit_cnt == '0));

    // R8: the bit count never passes one byte.
    a_r8_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= BYTE_END);

endmodule

// File: rtl/eeprom_slave.sv
// Top level: pin synchronisers, bus event detector, protocol engine, memory.
// Assumes: SDA is open-drain; the pad pulls low when sda_oe is 1.
module eeprom_slave #(
    parameter int         AW          = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_HI      = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);

    logic [1:0]    pins_s;
    logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    eeprom_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (pins_s)
    );

    eeprom_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (pins_s[1]),
        .sda_s    (pins_s[0]),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eeprom_ctrl #(.AW(AW), .DW(DW), .DEV_HI(DEV_HI)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .dev_sel   (dev_sel),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .sda_oe    (sda_oe)
    );

    eeprom_regfile #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/eeprom_slave_test.sv
// Bench: a bit-level bus master plus a behavioural memory/pointer model.
// The slave enable is compared with the model on every cycle of each SCL high phase.
module eeprom_slave_test;

    localparam logic [2:0] PINS = 3'b011;
    localparam logic [7:0] DEVW = {4'b1010, PINS, 1'b0};
    localparam logic [7:0] DEVR = {4'b1010, PINS, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_bus;
    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;
    bit         done = 1'b0;
    logic [7:0] ref_mem [256];
    int         ref_ptr = 0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    eeprom_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_m),
        .sda_in  (sda_bus),
        .dev_sel (PINS),
        .sda_oe  (sda_oe)
    );

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One SCL period; the enable is compared on every cycle of the high phase.
    task automatic bus_bit(input logic drive, input logic exp_oe, input string tag,
                           output logic seen);
        bit   bad = 1'b0;
        logic got = exp_oe;
        ticks(4);
        sda_m = drive;
        ticks(16);
        scl_m = 1'b1;
        seen = 1'b1;
        for (int i = 0; i < 20; i++) begin
            ticks(1);
            if (sda_oe !== exp_oe) begin
                bad = 1'b1;
                got = sda_oe;
            end
            if (i == 10) seen = sda_bus;
        end
        scl_m = 1'b0;
        check(!bad, tag, got, exp_oe);
    endtask

    task automatic bus_start();
        ticks(4);
        sda_m = 1'b1;
        ticks(8);
        scl_m = 1'b1;
        ticks(10);
        sda_m = 1'b0;
        ticks(10);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        ticks(4);
        sda_m = 1'b0;
        ticks(8);
        scl_m = 1'b1;
        ticks(10);
        sda_m = 1'b1;
        ticks(10);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], 1'b0, tag, s);
        bus_bit(1'b1, exp_ack, tag, s);
    endtask

    task automatic read_byte(input logic [7:0] expv, input string tag);
        logic [7:0] got = '0;
        logic       s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, !expv[i], tag, s);
            got[i] = s;
        end
        check(got == expv, tag, got, expv);
        bus_bit(1'b1, 1'b0, "R7 nack release", s);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        bus_start();
        send_byte(DEVW, 1'b1, "R2 write addr ack");
        send_byte(a, 1'b1, "R3 word addr ack");
        send_byte(d, 1'b1, "R3 data ack");
        bus_stop();
        ref_mem[a] = d;
        ref_ptr = (a + 1) % 256;
    endtask

    task automatic do_cur_read(input string tag);
        bus_start();
        send_byte(DEVR, 1'b1, "R2 read addr ack");
        read_byte(ref_mem[ref_ptr], tag);
        bus_stop();
        ref_ptr = (ref_ptr + 1) % 256;
    endtask

    task automatic do_rnd_read(input logic [7:0] a, input string tag);
        bus_start();
        send_byte(DEVW, 1'b1, "R5 dummy write ack");
        send_byte(a, 1'b1, "R5 word addr ack");
        bus_start();
        send_byte(DEVR, 1'b1, "R5 read ack");
        read_byte(ref_mem[a], tag);
        bus_stop();
        ref_ptr = (a + 1) % 256;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        ticks(5);
        check(sda_oe == 1'b0, "R1 enable released in reset", sda_oe, 0);
        rst_n = 1'b1;
        ticks(10);
        check(sda_oe == 1'b0, "R1 enable released after reset", sda_oe, 0);

        // R1/R4: pointer starts at 0, memory cleared.
        do_cur_read("R1 R4 first read at pointer 0");
        do_cur_read("R4 pointer advanced");

        // R3 then R5 and R4.
        do_write(8'h10, 8'hA5);
        do_cur_read("R3 R4 read after write is addr+1");
        do_rnd_read(8'h10, "R5 random read of written byte");
        do_cur_read("R4 follows random read");

        // R5: dummy write stores nothing.
        do_write(8'h20, 8'h11);
        do_rnd_read(8'h20, "R5 dummy write left byte intact");

        // R6: wrap from 255 to 0.
        do_write(8'hFF, 8'h3C);
        do_cur_read("R6 pointer wrapped to 0");
        do_rnd_read(8'hFF, "R6 byte at top address");
        do_cur_read("R6 read wraps to 0");

        // R2: mismatched address is ignored along with its bytes.
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, 1'b0, "R2 mismatch no ack");
        send_byte(8'h55, 1'b0, "R2 ignored byte");
        send_byte(8'h66, 1'b0, "R2 ignored byte");
        bus_stop();
        do_cur_read("R2 pointer untouched by mismatch");
        do_rnd_read(8'h55, "R2 memory untouched by mismatch");

        // R8: data byte followed by repeated start is discarded.
        bus_start();
        send_byte(DEVW, 1'b1, "R8 write addr ack");
        send_byte(8'h30, 1'b1, "R8 word addr ack");
        send_byte(8'h77, 1'b1, "R8 data ack");
        bus_start();
        send_byte(DEVR, 1'b1, "R8 read ack");
        read_byte(ref_mem[8'h30], "R8 unstopped write discarded");
        bus_stop();
        ref_ptr = 8'h31;
        do_cur_read("R8 pointer after discarded write");

        // R8: partial byte then stop clears the bit count.
        bus_start();
        for (int i = 0; i < 3; i++) bus_bit(1'b1, 1'b0, "R8 partial byte silent", s);
        bus_stop();
        do_cur_read("R8 clean access after partial byte");

        // R9: enable behaviour is checked cycle by cycle during every high phase above.
        do_write(8'h81, 8'h5A);
        do_rnd_read(8'h81, "R9 R3 alternating bits");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule